// File: doc/BRIEF.md
# Prescaled Up/Down/Center-Aligned Timebase

This block is a programmable timebase. The input clock passes through a divider, and each divided tick steps a counter against a reload limit. The counter can run in one of three ways. It can count upward and wrap to zero. It can count downward and wrap to the limit. Or it can bounce between zero and the limit. Each wrap or turnaround produces a one-cycle update pulse and sets a sticky flag. The flag drives an interrupt output when the interrupt enable is set.

Software sets the block up through a small word-wide configuration port with four addresses: control, prescale, reload and status. Three control inputs act on the count directly. A level enable runs or freezes the count, a software update pulse restarts the count and the divider, and a clear pulse zeroes the count. A compare-window output shows whether the selected alignment mode would let compare events through in the current counting direction. A neighbouring compare stage would use this output.

Top module: `tick_timebase`

## Requirements
- R1: With control bits [1:0]=0 and control bit 2 (down) clear, the count steps 0,1,…,reload, then returns to 0. The step that wraps raises `upd_o` for one cycle, in the same cycle that `cnt_o` first shows the new value. The update period is reload+1 ticks.
- R2: With control bits [1:0]=0 and control bit 2 set, the count steps down from reload to 0, then reloads the reload value with an update pulse. A software update loads the count with the reload value.
- R3: With control bits [1:0] nonzero, the count climbs to reload and then falls to 0. An update pulse fires at each turnaround, so updates come every reload ticks. `dir_o` is 1 while falling and 0 while climbing. In edge modes `dir_o` shows control bit 2.
- R4: `cmp_win_o` depends on the value of control bits [1:0]. It is always 1 for value 0 and for value 3. For value 1 it is 1 only while falling, and for value 2 only while climbing.
- R5: The count advances once every prescale+1 enabled clocks. A prescale value written at address 1 takes effect at the next update event.
- R6: When control bit 3 (reload preload) is set, a reload value written at address 2 takes effect only after the next update event. When bit 3 is clear, it takes effect at once.
- R7: `ug_i` restarts the divider, loads the pending prescale and reload values, sets the count to 0 (or to reload in edge-down mode), starts climbing, and pulses `upd_o`. It sets the flag only when control bit 4 (counter-only request) is clear.
- R8: While `en_i` is high, a control write leaves bits [2:0] (alignment and direction) unchanged but still updates bits 3 to 5.
- R9: The flag sets on every counter update event and stays set. Writing address 3 with bit 0 = 0 clears it, and a set in the same cycle wins over the clear. `irq_o` equals the flag ANDed with control bit 5.
- R10: `clr_i` sets the count to 0 and starts climbing. While `en_i` is low, and with no update or clear pulse, the count holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | 0 control, 1 prescale, 2 reload, 3 status |
| cfg_wdata | input | CFG_W | Configuration write data |
| en_i | input | 1 | Counting enable (level) |
| ug_i | input | 1 | Software update pulse |
| clr_i | input | 1 | Counter clear pulse |
| cnt_o | output | CNT_W | Current count |
| dir_o | output | 1 | 1 while counting down |
| cmp_win_o | output | 1 | Compare events permitted in current direction |
| upd_o | output | 1 | One-cycle update event |
| flag_o | output | 1 | Sticky update flag |
| irq_o | output | 1 | Flag gated by interrupt enable |

## Verification
On every cycle, the assertions check these step-by-step properties:
- The count stays frozen while disabled, and it is zero after a clear.
- Edge-up steps are +1 or a wrap, and edge-down steps are −1 or an update.
- The flag stays set until a clearing write, and the interrupt never fires without the flag.
- A counter-only software update leaves the flag clear.
- The alignment field cannot change while running.

Only the bench scenarios, compared against the reference model, can show the periods that span many cycles. These are prescale×reload products, the center-aligned half rate and the direction windows of modes 1 to 3. The same applies to the point where a deferred prescale or preloaded reload value takes effect.

// File: rtl/tmb_pkg.sv
package tmb_pkg;

   typedef enum logic [1:0] {
      ALN_EDGE     = 2'd0,
      ALN_CTR_DN   = 2'd1,
      ALN_CTR_UP   = 2'd2,
      ALN_CTR_BOTH = 2'd3
   } align_e;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_PSC  = 2'd1;
   localparam logic [1:0] REG_ARR  = 2'd2;
   localparam logic [1:0] REG_STAT = 2'd3;

   localparam int CB_DIR = 2;
   localparam int CB_PRE = 3;
   localparam int CB_URS = 4;
   localparam int CB_IE  = 5;

endpackage

// File: rtl/tmb_prescaler.sv
module tmb_prescaler #(
   parameter int PSC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             ug_i,
   input  logic             load_i,
   input  logic [PSC_W-1:0] div_i,
   output logic             tick_o
);
   logic [PSC_W-1:0] div_q;
   logic [PSC_W-1:0] cnt_q;

   assign tick_o = en_i && (cnt_q == div_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
      end else begin
         if (ug_i)
            cnt_q <= '0;
         else if (en_i)
            cnt_q <= tick_o ? '0 : cnt_q + PSC_W'(1);
         if (load_i)
            div_q <= div_i;
      end
   end
endmodule

// File: rtl/tmb_counter.sv
module tmb_counter
   import tmb_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             ug_i,
   input  logic             clr_i,
   input  align_e           align_i,
   input  logic             down_i,
   input  logic [CNT_W-1:0] arr_act_i,
   input  logic [CNT_W-1:0] arr_wr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             cdown_o,
   output logic             evt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic             dn_q, dn_nx;
   logic             wrap;

   always_comb begin
      cnt_nx = cnt_q;
      dn_nx  = dn_q;
      wrap   = 1'b0;
      if (align_i == ALN_EDGE) begin
         if (!down_i) begin
            if (cnt_q >= arr_act_i) begin
               cnt_nx = '0;
               wrap   = 1'b1;
            end else begin
               cnt_nx = cnt_q + ONE;
            end
         end else begin
            if (cnt_q == '0) begin
               cnt_nx = arr_wr_i;
               wrap   = 1'b1;
            end else begin
               cnt_nx = cnt_q - ONE;
            end
         end
      end else if (!dn_q) begin
         if (cnt_q >= arr_act_i) begin
            wrap = 1'b1;
            if (arr_act_i == '0) begin
               cnt_nx = '0;
            end else begin
               cnt_nx = arr_act_i - ONE;
               dn_nx  = 1'b1;
            end
         end else begin
            cnt_nx = cnt_q + ONE;
         end
      end else begin
         if (cnt_q == '0) begin
            wrap   = 1'b1;
            dn_nx  = 1'b0;
            cnt_nx = (arr_act_i == '0) ? '0 : ONE;
         end else begin
            cnt_nx = cnt_q - ONE;
         end
      end
   end

   assign evt_o   = tick_i && !ug_i && !clr_i && wrap;
   assign cnt_o   = cnt_q;
   assign cdown_o = dn_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dn_q  <= 1'b0;
      end else if (ug_i) begin
         cnt_q <= (align_i == ALN_EDGE && down_i) ? arr_wr_i : '0;
         dn_q  <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         dn_q  <= 1'b0;
      end else if (tick_i) begin
         cnt_q <= cnt_nx;
         dn_q  <= dn_nx;
      end
   end
endmodule

// File: rtl/tmb_flag.sv
module tmb_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic cnt_evt_i,
   input  logic ug_i,
   input  logic quiet_ug_i,
   input  logic clr_wr_i,
   input  logic ie_i,
   output logic upd_o,
   output logic flag_o,
   output logic irq_o
);
   logic upd_q, flag_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         upd_q  <= 1'b0;
         flag_q <= 1'b0;
      end else begin
         upd_q <= cnt_evt_i | ug_i;
         if (cnt_evt_i || (ug_i && !quiet_ug_i))
            flag_q <= 1'b1;
         else if (clr_wr_i)
            flag_q <= 1'b0;
      end
   end

   assign upd_o  = upd_q;
   assign flag_o = flag_q;
   assign irq_o  = flag_q & ie_i;
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
   import tmb_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PSC_W       = 16,
   parameter int CFG_W       = 16,
   parameter bit HAS_PRELOAD = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [1:0]       cfg_addr,
   input  logic [CFG_W-1:0] cfg_wdata,
   input  logic             en_i,
   input  logic             ug_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             dir_o,
   output logic             cmp_win_o,
   output logic             upd_o,
   output logic             flag_o,
   output logic             irq_o
);
   localparam int CTRL_W = CB_IE + 1;

   if (CFG_W < CTRL_W) begin : g_bad_cfg
      $error("tick_timebase: CFG_W too narrow for control fields");
   end
   if (CNT_W < 2 || CNT_W > CFG_W) begin : g_bad_cnt
      $error("tick_timebase: CNT_W must be in 2..CFG_W");
   end
   if (PSC_W < 1 || PSC_W > CFG_W) begin : g_bad_psc
      $error("tick_timebase: PSC_W must be in 1..CFG_W");
   end

   align_e           mode_q;
   logic             dir_q, pre_q, urs_q, ie_q;
   logic [PSC_W-1:0] psc_q;
   logic [CNT_W-1:0] arr_q, arr_act;
   logic             wr_ctrl, wr_psc, wr_arr, clr_wr;
   logic             tick, evt, cdown;

   assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
   assign wr_psc  = cfg_we && (cfg_addr == REG_PSC);
   assign wr_arr  = cfg_we && (cfg_addr == REG_ARR);
   assign clr_wr  = cfg_we && (cfg_addr == REG_STAT) && !cfg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= ALN_EDGE;
         dir_q  <= 1'b0;
         pre_q  <= 1'b0;
         urs_q  <= 1'b0;
         ie_q   <= 1'b0;
         psc_q  <= '0;
         arr_q  <= '0;
      end else begin
         if (wr_ctrl) begin
            if (!en_i) begin
               mode_q <= align_e'(cfg_wdata[1:0]);
               dir_q  <= cfg_wdata[CB_DIR];
            end
            pre_q <= cfg_wdata[CB_PRE];
            urs_q <= cfg_wdata[CB_URS];
            ie_q  <= cfg_wdata[CB_IE];
         end
         if (wr_psc) psc_q <= cfg_wdata[PSC_W-1:0];
         if (wr_arr) arr_q <= cfg_wdata[CNT_W-1:0];
      end
   end

   if (HAS_PRELOAD) begin : g_preload
      logic [CNT_W-1:0] arr_sh_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            arr_sh_q <= '0;
         else if (ug_i || evt)
            arr_sh_q <= arr_q;
      end
      assign arr_act = pre_q ? arr_sh_q : arr_q;
   end else begin : g_direct
      assign arr_act = arr_q;
   end

   tmb_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (en_i),
      .ug_i   (ug_i),
      .load_i (ug_i | evt),
      .div_i  (psc_q),
      .tick_o (tick)
   );

   tmb_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .ug_i      (ug_i),
      .clr_i     (clr_i),
      .align_i   (mode_q),
      .down_i    (dir_q),
      .arr_act_i (arr_act),
      .arr_wr_i  (arr_q),
      .cnt_o     (cnt_o),
      .cdown_o   (cdown),
      .evt_o     (evt)
   );

   tmb_flag u_flag (
      .clk        (clk),
      .rst_n      (rst_n),
      .cnt_evt_i  (evt),
      .ug_i       (ug_i),
      .quiet_ug_i (urs_q),
      .clr_wr_i   (clr_wr),
      .ie_i       (ie_q),
      .upd_o      (upd_o),
      .flag_o     (flag_o),
      .irq_o      (irq_o)
   );

   assign dir_o = (mode_q == ALN_EDGE) ? dir_q : cdown;

   always_comb begin
      case (mode_q)
         ALN_CTR_DN: cmp_win_o = cdown;
         ALN_CTR_UP: cmp_win_o = !cdown;
         default:    cmp_win_o = 1'b1;
      endcase
   end
endmodule

// File: rtl/tick_timebase_chk.sv
module tick_timebase_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_we,
   input logic [1:0]       cfg_addr,
   input logic             wd0_i,
   input logic             en_i,
   input logic             ug_i,
   input logic             clr_i,
   input logic [CNT_W-1:0] cnt_o,
   input logic             upd_o,
   input logic             flag_o,
   input logic             irq_o,
   input logic [1:0]       mode_i,
   input logic             dir_i,
   input logic             urs_i
);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i && !ug_i && !clr_i) |=> $stable(cnt_o));

   a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !ug_i) |=> (cnt_o == '0));

   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o && !(cfg_we && cfg_addr == 2'd3 && !wd0_i)) |=> flag_o);

   a_r9_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);

   a_r7_quiet_ug: assert property (@(posedge clk) disable iff (!rst_n)
      (ug_i && urs_i && !flag_o) |=> !flag_o);

   a_r8_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
      en_i |=> $stable(mode_i));

   a_r1_up_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0 && !dir_i && !ug_i && !clr_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0));

   a_r2_down_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == 2'd0 && dir_i && !ug_i && !clr_i) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) - 1'b1 || upd_o));
endmodule

bind tick_timebase tick_timebase_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cfg_we   (cfg_we),
   .cfg_addr (cfg_addr),
   .wd0_i    (cfg_wdata[0]),
   .en_i     (en_i),
   .ug_i     (ug_i),
   .clr_i    (clr_i),
   .cnt_o    (cnt_o),
   .upd_o    (upd_o),
   .flag_o   (flag_o),
   .irq_o    (irq_o),
   .mode_i   (mode_q),
   .dir_i    (dir_q),
   .urs_i    (urs_q)
);

// File: tb/tb_tick_timebase.sv
`timescale 1ns/1ps
module tb_tick_timebase;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_addr = 2'd0;
   logic [15:0] cfg_wdata = 16'd0;
   logic        en_i = 1'b0, ug_i = 1'b0, clr_i = 1'b0;
   logic [15:0] cnt_o;
   logic        dir_o, cmp_win_o, upd_o, flag_o, irq_o;

   int n_chk = 0, n_fail = 0, wd = 0;
   string cur_tag = "R1";

   always #2.5 clk = ~clk;

   tick_timebase dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .en_i(en_i), .ug_i(ug_i), .clr_i(clr_i),
      .cnt_o(cnt_o), .dir_o(dir_o), .cmp_win_o(cmp_win_o), .upd_o(upd_o),
      .flag_o(flag_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model, advanced on each rising edge
   int m_mode, m_dir, m_pre, m_urs, m_ie, m_psc, m_pact, m_arr, m_arsh;
   int m_pc, m_cnt, m_cd, m_upd, m_flag;
   always @(posedge clk) begin
      int aeff, wd_v;
      bit tick, evt;
      if (!rst_n) begin
         m_mode = 0; m_dir = 0; m_pre = 0; m_urs = 0; m_ie = 0; m_psc = 0;
         m_pact = 0; m_arr = 0; m_arsh = 0; m_pc = 0; m_cnt = 0; m_cd = 0;
         m_upd = 0; m_flag = 0;
      end else begin
         aeff = m_pre ? m_arsh : m_arr;
         wd_v = int'(cfg_wdata);
         evt  = 1'b0;
         tick = en_i && (m_pc == m_pact);
         if (ug_i) m_pc = 0;
         else if (en_i) m_pc = tick ? 0 : m_pc + 1;
         if (ug_i) begin
            m_cnt = (m_mode == 0 && m_dir == 1) ? m_arr : 0;
            m_cd = 0;
         end else if (clr_i) begin
            m_cnt = 0; m_cd = 0;
         end else if (tick) begin
            if (m_mode == 0 && m_dir == 0) begin
               if (m_cnt >= aeff) begin m_cnt = 0; evt = 1'b1; end
               else m_cnt++;
            end else if (m_mode == 0) begin
               if (m_cnt == 0) begin m_cnt = m_arr; evt = 1'b1; end
               else m_cnt--;
            end else if (m_cd == 0) begin
               if (m_cnt >= aeff) begin
                  evt = 1'b1;
                  if (aeff == 0) m_cnt = 0;
                  else begin m_cnt = aeff - 1; m_cd = 1; end
               end else m_cnt++;
            end else begin
               if (m_cnt == 0) begin evt = 1'b1; m_cd = 0; m_cnt = (aeff == 0) ? 0 : 1; end
               else m_cnt--;
            end
         end
         if (ug_i || evt) begin m_pact = m_psc; m_arsh = m_arr; end
         m_upd = (evt || ug_i) ? 1 : 0;
         if (evt || (ug_i && m_urs == 0)) m_flag = 1;
         else if (cfg_we && cfg_addr == 2'd3 && cfg_wdata[0] == 1'b0) m_flag = 0;
         if (cfg_we && cfg_addr == 2'd0) begin
            if (!en_i) begin m_mode = wd_v & 3; m_dir = (wd_v >> 2) & 1; end
            m_pre = (wd_v >> 3) & 1; m_urs = (wd_v >> 4) & 1; m_ie = (wd_v >> 5) & 1;
         end
         if (cfg_we && cfg_addr == 2'd1) m_psc = wd_v;
         if (cfg_we && cfg_addr == 2'd2) m_arr = wd_v;
      end
   end

   // cycle-by-cycle comparison, away from the active edge
   always @(negedge clk) begin
      int exp_win;
      if (rst_n) begin
         exp_win = (m_mode == 1) ? m_cd : (m_mode == 2) ? 1 - m_cd : 1;
         chk({cur_tag, " count"}, int'(cnt_o), m_cnt);
         chk({cur_tag, " update"}, int'(upd_o), m_upd);
         chk("R3 direction", int'(dir_o), (m_mode == 0) ? m_dir : m_cd);
         chk("R4 compare window", int'(cmp_win_o), exp_win);
         chk("R9 flag", int'(flag_o), m_flag);
         chk("R9 irq", int'(irq_o), m_flag & m_ie);
      end
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<=150000", wd);
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end

   task automatic wr(input logic [1:0] a, input int d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic pulse_ug();
      ug_i = 1'b1;
      @(negedge clk);
      ug_i = 1'b0;
   endtask

   task automatic wait_upd();
      int k = 0;
      do begin @(negedge clk); k++; end while (!upd_o && k < 3000);
   endtask

   task automatic gap(output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!upd_o && n < 3000);
   endtask

   initial begin
      int n, n2, c, w, d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset count", int'(cnt_o), 0);
      chk("R9 reset flag", int'(flag_o), 0);
      chk("R1 reset update", int'(upd_o), 0);

      // R1 edge up, then R5 deferred prescale
      cur_tag = "R1";
      wr(2'd0, 0); wr(2'd1, 0); wr(2'd2, 4); pulse_ug(); wr(2'd3, 0);
      en_i = 1'b1;
      wait_upd(); gap(n);
      chk("R1 up period", n, 5);
      cur_tag = "R5";
      wr(2'd1, 2);
      wait_upd(); gap(n);
      chk("R5 prescaled period", n, 15);

      // R2 edge down
      cur_tag = "R2";
      en_i = 1'b0;
      wr(2'd0, 4); wr(2'd1, 0); wr(2'd2, 5); pulse_ug();
      chk("R2 update loads reload", int'(cnt_o), 5);
      wr(2'd3, 0);
      en_i = 1'b1;
      wait_upd(); gap(n);
      chk("R2 down period", n, 6);

      // R3 / R4 center-aligned variants
      for (int m = 1; m <= 3; m++) begin
         cur_tag = "R3";
         en_i = 1'b0;
         wr(2'd0, m); pulse_ug();
         en_i = 1'b1;
         wait_upd(); gap(n);
         chk("R3 center update spacing", n, 5);
         w = 0; d = 0;
         for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            w += int'(cmp_win_o); d += int'(dir_o);
         end
         chk("R3 down share of period", d, 5);
         chk("R4 window cycles per period", w, (m == 3) ? 10 : 5);
      end

      // R6 preload on, then off
      cur_tag = "R6";
      en_i = 1'b0;
      wr(2'd0, 8); wr(2'd2, 9); pulse_ug();
      en_i = 1'b1;
      wait_upd(); wr(2'd2, 3); gap(n); gap(n2);
      chk("R6 preload keeps old reload", 1 + n, 10);
      chk("R6 preload new reload after update", n2, 4);
      en_i = 1'b0;
      wr(2'd0, 0); wr(2'd2, 9); pulse_ug();
      en_i = 1'b1;
      wait_upd(); wr(2'd2, 2); gap(n);
      chk("R6 direct reload immediate", 1 + n, 3);

      // R7 software update with and without counter-only request
      cur_tag = "R7";
      en_i = 1'b0;
      wr(2'd0, 16); wr(2'd3, 0); pulse_ug();
      chk("R7 quiet update flag", int'(flag_o), 0);
      chk("R7 quiet update pulse", int'(upd_o), 1);
      chk("R7 update count", int'(cnt_o), 0);
      wr(2'd0, 0); pulse_ug();
      chk("R7 update sets flag", int'(flag_o), 1);

      // R8 mode write ignored while running, enable bit still taken
      cur_tag = "R8";
      wr(2'd0, 3); wr(2'd2, 5); pulse_ug();
      en_i = 1'b1;
      wr(2'd0, 32);
      wait_upd(); gap(n);
      chk("R8 center rate kept", n, 5);
      chk("R9 irq with enable", int'(irq_o), 1);

      // R9 sticky flag and clear
      cur_tag = "R9";
      en_i = 1'b0;
      wr(2'd3, 1);
      chk("R9 bit0 one does not clear", int'(flag_o), 1);
      wr(2'd3, 0);
      chk("R9 clear", int'(flag_o), 0);
      chk("R9 irq follows flag", int'(irq_o), 0);
      wr(2'd0, 0); pulse_ug();
      chk("R9 flag set, irq masked", int'(irq_o), 0);

      // R10 clear pulse and hold
      cur_tag = "R10";
      en_i = 1'b1;
      repeat (3) @(negedge clk);
      clr_i = 1'b1; @(negedge clk); clr_i = 1'b0;
      chk("R10 clear zeroes count", int'(cnt_o), 0);
      @(negedge clk);
      en_i = 1'b0;
      @(negedge clk);
      c = int'(cnt_o);
      repeat (5) @(negedge clk);
      chk("R10 disabled hold", int'(cnt_o), c);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule